// File: doc/BRIEF.md
# Memory Error Logger with Interrupt Requests

This block records error events for one memory controller slice and for its board-level bus port. Memory error events arrive as one-cycle pulses, one line per error class, together with the access address and the ECC syndrome that the datapath computed. The block keeps a sticky four-bit status word. When a first error arrives it captures the failing address and all syndrome slices. A second error marks the capture as no longer trustworthy. Bus error pulses go into a separate sticky four-bit word.

Software reaches the state through a small register port with read and write strobes and a four-bit register index. Read data is registered. The status word has two views: a plain view, and a view that clears the word in the same access that reads it. Two interrupt configuration registers each hold an enable bit, an 8-bit priority and a 7-bit destination. When a qualifying event arrives and the matching enable is set, the block raises a one-cycle interrupt request that carries that priority and destination.

Top module: `mem_err_logger`

## Requirements
- R1: A memory error pulse sets its status bit one cycle later. The status bits are: bit 2 correctable read error, bit 1 uncorrectable read error, bit 0 uncorrectable partial-write error. Status bits stay set until they are cleared.
- R2: Status bit 3 (multiple error) is set when a memory error pulse arrives while the effective status is non-zero. It is also set when two or more classes pulse in the same cycle. It stays set until the status is cleared.
- R3: The failing address and the syndrome slices are captured only by an error that arrives while the effective status is zero. Later errors leave them unchanged.
- R4: A read of index 0 returns the status in bits 3:0 and changes nothing. Writes to index 0 are ignored.
- R5: A read of index 1 returns the same status value and clears the status in that access. A memory error pulse in the same cycle is kept and is treated as a first error.
- R6: The memory interrupt request pulses one cycle after a correctable read error or a partial-write error, but only while the enable bit of index 8 is set. An uncorrectable read error never raises it. While it pulses, the priority and destination outputs carry fields 15:8 and 6:0 of index 8.
- R7: Interrupt configuration registers (index 8 memory, index 9 bus) store bit 16 enable, bits 15:8 priority and bits 6:0 destination. Bit 7 always reads 0, and bits 31:17 are neither stored nor read back.
- R8: Bus error pulses set bits of index 10. The bits are: 3 sender address error, 2 sender data error, 1 address error seen from another initiator, 0 data error seen from another initiator. Any write to index 10 clears all four bits, and a pulse in the same cycle is kept.
- R9: The bus interrupt request pulses one cycle after a sender address error, only while the enable bit of index 9 is set, and carries the priority and destination fields of index 9. The other bus error classes raise no request.
- R10: Read data appears on the cycle after the read strobe and is zero otherwise. Index 2 returns failing-address bits 39:32 and index 3 returns bits 31:0. Indices 4 to 7 return syndrome slices 0 to 3, where slice n is syndrome bits 16n+15:16n. Unmapped indices read 0.
- R11: After reset, every status, capture, configuration and bus error bit is 0 and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_evt | input | 3 | Memory error pulses: 2 correctable read, 1 uncorrectable read, 0 partial-write uncorrectable |
| mem_addr | input | 40 | Address of the access that pulsed |
| mem_synd | input | 64 | Syndrome of the access that pulsed, four 16-bit slices |
| bus_evt | input | 4 | Bus error pulses, same bit order as index 10 |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mem_irq_req | output | 1 | Memory error interrupt request pulse |
| mem_irq_prio | output | 8 | Memory interrupt priority |
| mem_irq_dest | output | 7 | Memory interrupt destination |
| bus_irq_req | output | 1 | Bus error interrupt request pulse |
| bus_irq_prio | output | 8 | Bus interrupt priority |
| bus_irq_dest | output | 7 | Bus interrupt destination |

## Verification
The checker watches the following on every cycle:
- status and bus error bits stay sticky unless a clear is in progress;
- the multiple-error bit holds;
- the captured address stays frozen while any status bit is set;
- every interrupt request traces back to an enabled event of an interrupting class;
- a clear with no simultaneous event empties the status.

Other behaviours need the bench's scenarios to show them: the register layouts, bit 7 reading zero, the exact read-data values, an event that coincides with a read-and-clear or a bus clear, and an interrupt that is missing for an uncorrectable read or a sender data error.

// File: rtl/mel_pkg.sv
package mel_pkg;

   typedef enum logic [3:0] {
      IDX_STAT     = 4'd0,
      IDX_STAT_RC  = 4'd1,
      IDX_ADDR_HI  = 4'd2,
      IDX_ADDR_LO  = 4'd3,
      IDX_SYND0    = 4'd4,
      IDX_MEM_IRQ  = 4'd8,
      IDX_BUS_IRQ  = 4'd9,
      IDX_BUS_ERR  = 4'd10
   } reg_idx_e;

   typedef struct packed {
      logic       en;
      logic [7:0] prio;
      logic       zero;
      logic [6:0] dest;
   } irq_cfg_t;

endpackage

// File: rtl/mel_mem_status.sv
module mel_mem_status #(
   parameter int ADDR_W = 40,
   parameter int SYND_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        evt,
   input  logic [ADDR_W-1:0] addr,
   input  logic [SYND_W-1:0] synd,
   input  logic              clr,
   output logic [3:0]        status,
   output logic [ADDR_W-1:0] cap_addr,
   output logic [SYND_W-1:0] cap_synd
);
   logic [3:0] prior;
   logic       hit;
   logic       two;
   logic       mult;

   always_comb begin
      prior = clr ? 4'd0 : status;
      hit   = |evt;
      two   = (evt[0] & evt[1]) | (evt[0] & evt[2]) | (evt[1] & evt[2]);
      mult  = hit && ((prior != 4'd0) || two);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status   <= '0;
         cap_addr <= '0;
         cap_synd <= '0;
      end else begin
         status <= prior | {mult, evt};
         if (hit && prior == 4'd0) begin
            cap_addr <= addr;
            cap_synd <= synd;
         end
      end
   end
endmodule

// File: rtl/mel_bus_err.sv
module mel_bus_err #(
   parameter int BITS = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [BITS-1:0] evt,
   input  logic            clr,
   output logic [BITS-1:0] err
);
   always_ff @(posedge clk) begin
      if (!rst_n) err <= '0;
      else        err <= (clr ? '0 : err) | evt;
   end
endmodule

// File: rtl/mel_irq_cfg.sv
module mel_irq_cfg
   import mel_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  logic [15:0] wbits,
   output irq_cfg_t    cfg
);
   always_ff @(posedge clk) begin
      if (!rst_n) cfg <= '0;
      else if (wr) begin
         cfg.en   <= wbits[15];
         cfg.prio <= wbits[14:7];
         cfg.zero <= 1'b0;
         cfg.dest <= wbits[6:0];
      end
   end
endmodule

// File: rtl/mem_err_logger.sv
module mem_err_logger
   import mel_pkg::*;
#(
   parameter int ADDR_W  = 40,
   parameter int SLICES  = 4,
   parameter int SLICE_W = 16,
   localparam int SYND_W = SLICES * SLICE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mem_evt,
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic [SYND_W-1:0] mem_synd,
   input  logic [3:0]        bus_evt,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [3:0]        reg_idx,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_irq_req,
   output logic [7:0]        mem_irq_prio,
   output logic [6:0]        mem_irq_dest,
   output logic              bus_irq_req,
   output logic [7:0]        bus_irq_prio,
   output logic [6:0]        bus_irq_dest
);
   localparam int SYND_BASE = int'(IDX_SYND0);

   if (ADDR_W <= 32 || ADDR_W > 64) begin : g_bad_addr
      $error("mem_err_logger: ADDR_W must be 33..64");
   end
   if (SLICES < 1 || SLICES > 4) begin : g_bad_slices
      $error("mem_err_logger: SLICES must be 1..4");
   end
   if (SLICE_W < 1 || SLICE_W > 32) begin : g_bad_slice_w
      $error("mem_err_logger: SLICE_W must be 1..32");
   end

   logic              rc_clr;
   logic              bus_clr;
   logic [3:0]        status;
   logic [ADDR_W-1:0] cap_addr;
   logic [SYND_W-1:0] cap_synd;
   logic [3:0]        bus_err;
   logic [15:0]       cfg_bits;
   irq_cfg_t          cfg [2];
   logic [SLICE_W-1:0] slc [SLICES];
   logic [31:0]       rd_mux;
   logic              unused_wdata;

   assign rc_clr       = reg_rd && (reg_idx == IDX_STAT_RC);
   assign bus_clr      = reg_wr && (reg_idx == IDX_BUS_ERR);
   assign cfg_bits     = {reg_wdata[16:8], reg_wdata[6:0]};
   assign unused_wdata = ^{reg_wdata[31:17], reg_wdata[7]};

   mel_mem_status #(.ADDR_W(ADDR_W), .SYND_W(SYND_W)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (mem_evt),
      .addr     (mem_addr),
      .synd     (mem_synd),
      .clr      (rc_clr),
      .status   (status),
      .cap_addr (cap_addr),
      .cap_synd (cap_synd)
   );

   mel_bus_err #(.BITS(4)) u_bus (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (bus_evt),
      .clr   (bus_clr),
      .err   (bus_err)
   );

   for (genvar g = 0; g < 2; g++) begin : g_cfg
      localparam reg_idx_e SEL = (g == 0) ? IDX_MEM_IRQ : IDX_BUS_IRQ;
      mel_irq_cfg u_cfg (
         .clk   (clk),
         .rst_n (rst_n),
         .wr    (reg_wr && (reg_idx == SEL)),
         .wbits (cfg_bits),
         .cfg   (cfg[g])
      );
   end

   for (genvar s = 0; s < SLICES; s++) begin : g_slice
      assign slc[s] = cap_synd[s*SLICE_W +: SLICE_W];
   end

   always_comb begin
      rd_mux = '0;
      case (reg_idx)
         IDX_STAT, IDX_STAT_RC: rd_mux = {28'd0, status};
         IDX_ADDR_HI:           rd_mux = 32'(cap_addr[ADDR_W-1:32]);
         IDX_ADDR_LO:           rd_mux = cap_addr[31:0];
         IDX_MEM_IRQ:           rd_mux = {15'd0, cfg[0]};
         IDX_BUS_IRQ:           rd_mux = {15'd0, cfg[1]};
         IDX_BUS_ERR:           rd_mux = {28'd0, bus_err};
         default:               rd_mux = '0;
      endcase
      for (int i = 0; i < SLICES; i++) begin
         if (int'(reg_idx) == SYND_BASE + i) rd_mux = 32'(slc[i]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rdata   <= '0;
         mem_irq_req <= 1'b0;
         bus_irq_req <= 1'b0;
      end else begin
         reg_rdata   <= reg_rd ? rd_mux : '0;
         mem_irq_req <= cfg[0].en & (mem_evt[2] | mem_evt[0]);
         bus_irq_req <= cfg[1].en & bus_evt[3];
      end
   end

   assign mem_irq_prio = cfg[0].prio;
   assign mem_irq_dest = cfg[0].dest;
   assign bus_irq_prio = cfg[1].prio;
   assign bus_irq_dest = cfg[1].dest;
endmodule

// File: rtl/mel_checker.sv
module mel_checker #(
   parameter int ADDR_W = 40
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        mem_evt,
   input logic [3:0]        bus_evt,
   input logic              rc_clr,
   input logic              bus_clr,
   input logic [3:0]        status,
   input logic [ADDR_W-1:0] cap_addr,
   input logic [3:0]        bus_err,
   input logic              mem_irq_req,
   input logic              bus_irq_req,
   input logic              mem_en,
   input logic              bus_en
);
   assert_status_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_evt != 3'd0) |=> ((status[2:0] & $past(mem_evt)) == $past(mem_evt)));

   assert_mult_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (status[3] && !rc_clr) |=> status[3]);

   assert_capture_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (status != 4'd0 && !rc_clr) |=> $stable(cap_addr));

   assert_rc_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rc_clr && mem_evt == 3'd0) |=> (status == 4'd0));

   assert_mem_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_irq_req |-> ($past(mem_en) && ($past(mem_evt[2]) || $past(mem_evt[0]))));

   assert_bus_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_clr |=> ((bus_err & $past(bus_err)) == $past(bus_err)));

   assert_bus_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_irq_req |-> ($past(bus_en) && $past(bus_evt[3])));
endmodule

bind mem_err_logger mel_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mem_evt     (mem_evt),
   .bus_evt     (bus_evt),
   .rc_clr      (rc_clr),
   .bus_clr     (bus_clr),
   .status      (status),
   .cap_addr    (cap_addr),
   .bus_err     (bus_err),
   .mem_irq_req (mem_irq_req),
   .bus_irq_req (bus_irq_req),
   .mem_en      (cfg[0].en),
   .bus_en      (cfg[1].en)
);

// File: tb/mem_err_logger_tb.sv
module mem_err_logger_tb_top;

   typedef struct packed {
      logic [1:0]  op;    // 0 mem event, 1 bus event, 2 write, 3 read-check
      logic [3:0]  idx;
      logic [39:0] data;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 33;
   localparam vec_t VEC [0:NV-1] = '{
      '{2'd3, 4'd0,  40'h0,          32'h0,        4'd11}, // R11
      '{2'd2, 4'd8,  40'hFFFFABFF,   32'h0,        4'd7},  // R7
      '{2'd3, 4'd8,  40'h0,          32'h1AB7F,    4'd7},  // R7
      '{2'd0, 4'd4,  40'h123456789A, 32'h1,        4'd6},  // R6
      '{2'd3, 4'd0,  40'h0,          32'h4,        4'd1},  // R1
      '{2'd3, 4'd2,  40'h0,          32'h12,       4'd10}, // R10
      '{2'd3, 4'd3,  40'h0,          32'h3456789A, 4'd10}, // R10
      '{2'd3, 4'd4,  40'h0,          32'h789A,     4'd3},  // R3
      '{2'd3, 4'd7,  40'h0,          32'h789D,     4'd3},  // R3
      '{2'd0, 4'd2,  40'h1111,       32'h0,        4'd6},  // R6
      '{2'd3, 4'd0,  40'h0,          32'hE,        4'd2},  // R2
      '{2'd3, 4'd3,  40'h0,          32'h3456789A, 4'd3},  // R3
      '{2'd3, 4'd5,  40'h0,          32'h789B,     4'd3},  // R3
      '{2'd3, 4'd1,  40'h0,          32'hE,        4'd5},  // R5
      '{2'd3, 4'd0,  40'h0,          32'h0,        4'd5},  // R5
      '{2'd0, 4'd1,  40'hAABBBBCCCC, 32'h1,        4'd6},  // R6
      '{2'd3, 4'd2,  40'h0,          32'hAA,       4'd3},  // R3
      '{2'd3, 4'd4,  40'h0,          32'hCCCC,     4'd3},  // R3
      '{2'd2, 4'd8,  40'h0,          32'h0,        4'd7},  // R7
      '{2'd3, 4'd8,  40'h0,          32'h0,        4'd7},  // R7
      '{2'd0, 4'd4,  40'h5,          32'h0,        4'd6},  // R6
      '{2'd3, 4'd1,  40'h0,          32'hD,        4'd2},  // R2
      '{2'd2, 4'd9,  40'h15512,      32'h0,        4'd9},  // R9
      '{2'd1, 4'd4,  40'h0,          32'h0,        4'd9},  // R9
      '{2'd1, 4'd8,  40'h0,          32'h1,        4'd9},  // R9
      '{2'd1, 4'd3,  40'h0,          32'h0,        4'd9},  // R9
      '{2'd3, 4'd10, 40'h0,          32'hF,        4'd8},  // R8
      '{2'd2, 4'd10, 40'h0,          32'h0,        4'd8},  // R8
      '{2'd3, 4'd10, 40'h0,          32'h0,        4'd8},  // R8
      '{2'd2, 4'd0,  40'hF,          32'h0,        4'd4},  // R4
      '{2'd3, 4'd0,  40'h0,          32'h0,        4'd4},  // R4
      '{2'd3, 4'd15, 40'h0,          32'h0,        4'd10}, // R10
      '{2'd3, 4'd9,  40'h0,          32'h15512,    4'd7}   // R7
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  mem_evt = '0;
   logic [39:0] mem_addr = '0;
   logic [63:0] mem_synd = '0;
   logic [3:0]  bus_evt = '0;
   logic        reg_rd = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_idx = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_irq_req, bus_irq_req;
   logic [7:0]  mem_irq_prio, bus_irq_prio;
   logic [6:0]  mem_irq_dest, bus_irq_dest;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   mem_err_logger dut_i (
      .clk(clk), .rst_n(rst_n), .mem_evt(mem_evt), .mem_addr(mem_addr),
      .mem_synd(mem_synd), .bus_evt(bus_evt), .reg_rd(reg_rd), .reg_wr(reg_wr),
      .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_irq_req(mem_irq_req), .mem_irq_prio(mem_irq_prio), .mem_irq_dest(mem_irq_dest),
      .bus_irq_req(bus_irq_req), .bus_irq_prio(bus_irq_prio), .bus_irq_dest(bus_irq_dest)
   );

   function automatic logic [63:0] synd_of(input logic [39:0] a);
      return {a[15:0] + 16'd3, a[15:0] + 16'd2, a[15:0] + 16'd1, a[15:0]};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic mem_pulse(input logic [2:0] e, input logic [39:0] a);
      @(negedge clk);
      mem_evt = e; mem_addr = a; mem_synd = synd_of(a);
      @(negedge clk);
      mem_evt = '0;
   endtask

   task automatic bus_pulse(input logic [3:0] e);
      @(negedge clk);
      bus_evt = e;
      @(negedge clk);
      bus_evt = '0;
   endtask

   task automatic wr(input logic [3:0] i, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_idx = i; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] i, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_rd = 1'b1; reg_idx = i;
      @(negedge clk);
      reg_rd = 1'b0;
      check(tag, reg_rdata, exp);
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=0x0 expected=0x1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state at the ports
      check("R11 mem_irq_req after reset", {31'd0, mem_irq_req}, 32'd0);
      check("R11 bus_irq_req after reset", {31'd0, bus_irq_req}, 32'd0);
      check("R11 rdata idle", reg_rdata, 32'd0);

      for (int v = 0; v < NV; v++) begin
         case (VEC[v].op)
            2'd0: begin
               mem_pulse(VEC[v].idx[2:0], VEC[v].data);
               check($sformatf("R%0d vec%0d mem_irq_req", VEC[v].req, v), {31'd0, mem_irq_req}, VEC[v].exp);
            end
            2'd1: begin
               bus_pulse(VEC[v].idx);
               check($sformatf("R%0d vec%0d bus_irq_req", VEC[v].req, v), {31'd0, bus_irq_req}, VEC[v].exp);
            end
            2'd2: wr(VEC[v].idx, VEC[v].data[31:0]);
            default: rd(VEC[v].idx, VEC[v].exp, $sformatf("R%0d vec%0d read idx %0d", VEC[v].req, v, VEC[v].idx));
         endcase
      end

      // R5: read-and-clear with a simultaneous event keeps the event
      mem_pulse(3'b010, 40'h7777);
      @(negedge clk);
      reg_rd = 1'b1; reg_idx = 4'd1; mem_evt = 3'b001; mem_addr = 40'h99_0000_4444; mem_synd = synd_of(40'h99_0000_4444);
      @(negedge clk);
      reg_rd = 1'b0; mem_evt = '0;
      check("R5 rc returns old status", reg_rdata, 32'h2);
      rd(4'd0, 32'h1, "R5 event survives clear");
      rd(4'd2, 32'h99, "R5 event after clear captures address");
      rd(4'd1, 32'h1, "R5 second clear");

      // R2: two classes in one cycle
      mem_pulse(3'b110, 40'h1);
      rd(4'd1, 32'hE, "R2 simultaneous classes set mult");

      // R8: bus clear with simultaneous event keeps the event
      @(negedge clk);
      reg_wr = 1'b1; reg_idx = 4'd10; bus_evt = 4'b0001;
      @(negedge clk);
      reg_wr = 1'b0; bus_evt = '0;
      rd(4'd10, 32'h1, "R8 event survives bus clear");
      wr(4'd10, 32'h0);
      rd(4'd10, 32'h0, "R8 bus clear");

      // R6: priority and destination carried with the request
      wr(4'd8, 32'h0001_3C05);
      mem_pulse(3'b001, 40'h2);
      check("R6 mem request", {31'd0, mem_irq_req}, 32'd1);
      check("R6 mem priority", {24'd0, mem_irq_prio}, 32'h3C);
      check("R6 mem destination", {25'd0, mem_irq_dest}, 32'h05);
      @(negedge clk);
      check("R6 request is one cycle", {31'd0, mem_irq_req}, 32'd0);
      // R9: bus request fields
      bus_pulse(4'b1000);
      check("R9 bus request", {31'd0, bus_irq_req}, 32'd1);
      check("R9 bus priority", {24'd0, bus_irq_prio}, 32'h55);
      check("R9 bus destination", {25'd0, bus_irq_dest}, 32'h12);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule